// File: doc/BRIEF.md
# Serial-Synapse Leaky Integrate-and-Fire Neuron

This block is one spiking-neuron processing element that advances a leaky integrate-and-fire neuron by a single simulation time step each time it is started. It works through its inputs one per clock tick. Each input is a one-bit spike that, when set, gates a fixed signed weight from a small local weight table. The weight goes either straight into the membrane potential or into one of several synapse accumulators, and each synapse accumulator has its own exponential time constant. After the inputs, every synapse accumulator is added into the membrane and then decayed. The membrane is decayed last. Decay is done by shift-and-subtract, with no multiplier.

After its own decay the membrane is compared against a firing threshold. On a crossing the neuron emits a one-cycle spike and its membrane drops to a negative reset level, which makes it less sensitive for a while (relative refractoriness). For a fixed number of steps after a spike, all incoming spikes are also ignored (absolute refractoriness). A network controller pulses `start` once per time step. It collects `spikeOut` and may read `memOut` when `done` pulses.

Top module: `spikeNeuronPe`

## Requirements
- R1: After reset, `memOut` is 0, all synapse accumulators are 0, the absolute-refractory count is 0, and `busy`, `done` and `spikeOut` are low.
- R2: A `start` seen while idle runs one time step of exactly NIN+(NSYN+1)(NTERM+1) clock ticks, which is 18 with the defaults NIN=12, NSYN=2, NTERM=1. `done` rises on the last tick's edge and is high for one cycle. A `start` seen while `busy` is ignored.
- R3: `spikeIn` is sampled on the start edge; later changes have no effect on that step. For every sampled bit i that is 1, weight i is added into the accumulator named by the 4-bit target i, where 0 means the membrane and k (1..NSYN) means synapse accumulator k.
- R4: After the inputs, synapse accumulators 1..NSYN are handled in ascending order. Each one's pre-decay value is added into the membrane, and then that accumulator is decayed.
- R5: Decay of a value y is y minus the sum of (y arithmetically shifted right by k) over the accumulator's shift set. The defaults use shift 4 for the membrane, 2 for synapse 1 and 3 for synapse 2. The membrane is decayed after all synapse additions.
- R6: When y is positive and any bit below position min(k) is 1, the decayed value is one lower than in R5, so a positive value reaches 0 (for example, 1 decays to 0 with shift 4).
- R7: If the decayed membrane is at least +255, `spikeOut` is high together with `done` and `memOut` becomes -255. Otherwise `spikeOut` stays low.
- R8: For the 2 steps after a firing step, all input spikes are ignored, while the synapse additions and all decays continue.
- R9: Every addition into an accumulator saturates to the 10-bit signed range -512..+511 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins one time step when the block is idle |
| spikeIn | input | NIN | Input spikes for this step, one bit per input |
| busy | output | 1 | High while a time step is in progress |
| done | output | 1 | One-cycle pulse at the end of a step |
| spikeOut | output | 1 | Firing flag, valid in the cycle `done` is high |
| memOut | output | 10 | Membrane potential, two's complement |

## Verification
A wrong synapse accumulator never appears at the ports directly. It shows up in `memOut` at the end of the same step, through the fold, and then again in every later step, because that accumulator keeps being added in. A wrong refractory count or a dropped round-off correction shows up only over a run of steps, as a membrane that drifts from the reference or a spike one step early or late. For this reason the bench checks `memOut` and `spikeOut` after every step against a step-level reference model, and uses hand-worked values for the corner cases. A wrong tick counter shows up at once as `done` arriving off the 18-cycle mark.

// File: rtl/snpPkg.sv
package snpPkg;
  localparam int POT_W = 10;

  typedef logic signed [POT_W-1:0] pot_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic       latch;
    logic       inAdd;
    logic [7:0] inIdx;
    logic       shiftAdd;
    logic       commit;
    logic [3:0] accSel;
    logic [3:0] term;
    logic       finish;
  } strobe_t;

  function automatic pot_t satAdd(pot_t a, pot_t b);
    logic signed [POT_W:0] s;
    s = {a[POT_W-1], a} + {b[POT_W-1], b};
    if (s[POT_W] != s[POT_W-1])
      return s[POT_W] ? {1'b1, {(POT_W-1){1'b0}}} : {1'b0, {(POT_W-1){1'b1}}};
    return s[POT_W-1:0];
  endfunction
endpackage

// File: rtl/snpCtrl.sv
module snpCtrl
  import snpPkg::*;
#(
  parameter int NIN   = 12,
  parameter int NSYN  = 2,
  parameter int NTERM = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output logic    busy,
  output logic    done,
  output strobe_t stb
);
  localparam int TICKS = NIN + (NSYN + 1) * (NTERM + 1);
  localparam int CW    = $clog2(TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (cnt == CW'(TICKS - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    int r, g, p;
    r   = 0;
    g   = 0;
    p   = 0;
    stb = '0;
    stb.latch = start && !busy;
    if (busy) begin
      if (int'(cnt) < NIN) begin
        stb.inAdd = 1'b1;
        stb.inIdx = 8'(cnt);
      end else begin
        r = int'(cnt) - NIN;
        g = r / (NTERM + 1);
        p = r % (NTERM + 1);
        // synapses first (1..NSYN), membrane (0) last
        stb.accSel = (g < NSYN) ? 4'(g + 1) : 4'd0;
        if (p < NTERM) begin
          stb.shiftAdd = 1'b1;
          stb.term     = 4'(p);
        end else begin
          stb.commit = 1'b1;
          stb.finish = (g == NSYN);
        end
      end
    end
  end
endmodule

// File: rtl/snpDatapath.sv
module snpDatapath
  import snpPkg::*;
#(
  parameter int NIN        = 12,
  parameter int NSYN       = 2,
  parameter int NTERM      = 1,
  parameter logic [NIN*POT_W-1:0]        WEIGHTS = '0,
  parameter logic [NIN*4-1:0]            TARGETS = '0,
  parameter logic [(NSYN+1)*NTERM*4-1:0] SHIFTS  = '0,
  parameter int REFR_STEPS = 2,
  parameter int THRESH     = 255,
  parameter int RESET_V    = -255
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        stb,
  input  logic [NIN-1:0] spikeIn,
  output logic           spikeOut,
  output pot_t           memOut
);
  localparam int AW = $clog2(NSYN + 1);
  localparam int IW = $clog2(NIN);
  localparam int RW = $clog2(REFR_STEPS + 1);
  localparam int SW = POT_W + 2;

  pot_t       wMem [NIN];
  logic [3:0] tMem [NIN];
  logic [3:0] shTab[NSYN+1][NTERM];

  for (genvar i = 0; i < NIN; i++) begin : g_wmem
    assign wMem[i] = WEIGHTS[i*POT_W +: POT_W];
    assign tMem[i] = TARGETS[i*4 +: 4];
  end
  for (genvar a = 0; a <= NSYN; a++) begin : g_acc
    for (genvar t = 0; t < NTERM; t++) begin : g_term
      assign shTab[a][t] = SHIFTS[(a*NTERM+t)*4 +: 4];
    end
  end

  pot_t                  acc[NSYN+1];
  logic signed [SW-1:0]  sumReg;
  logic [NIN-1:0]        spkReg;
  logic [RW-1:0]         refrCnt;

  logic [AW-1:0]         selIdx;
  logic [IW-1:0]         inIdx;
  logic [AW-1:0]         tgtIdx;
  pot_t                  selVal;
  logic signed [SW-1:0]  selWide, shifted, sumNext, decWide;
  logic [3:0]            shAmt, minK;
  logic [POT_W-1:0]      lowMask;
  logic                  corr, fire;
  pot_t                  decVal;

  assign selIdx  = AW'(stb.accSel);
  assign inIdx   = IW'(stb.inIdx);
  assign tgtIdx  = AW'(tMem[inIdx]);
  assign selVal  = acc[selIdx];
  assign selWide = {{2{selVal[POT_W-1]}}, selVal};

  always_comb begin
    shAmt = shTab[selIdx][0];
    minK  = 4'hF;
    for (int t = 0; t < NTERM; t++) begin
      if (stb.term == 4'(t)) shAmt = shTab[selIdx][t];
      if (shTab[selIdx][t] < minK) minK = shTab[selIdx][t];
    end
    for (int b = 0; b < POT_W; b++) lowMask[b] = (b < int'(minK));
  end

  assign shifted = selWide >>> shAmt;
  assign sumNext = ((stb.term == 4'd0) ? '0 : sumReg) + shifted;
  // round-off fix: positive values with residue bits lose the +1
  assign corr    = !selVal[POT_W-1] && ((selVal & lowMask) != '0);
  assign decWide = selWide + ~sumReg + SW'(!corr);
  assign decVal  = decWide[POT_W-1:0];
  assign fire    = (int'(decVal) >= THRESH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a <= NSYN; a++) acc[a] <= '0;
      sumReg   <= '0;
      spkReg   <= '0;
      refrCnt  <= '0;
      spikeOut <= 1'b0;
    end else begin
      spikeOut <= 1'b0;
      if (stb.latch) spkReg <= spikeIn;
      if (stb.inAdd && spkReg[inIdx] && refrCnt == '0)
        acc[tgtIdx] <= satAdd(acc[tgtIdx], wMem[inIdx]);
      if (stb.shiftAdd) sumReg <= sumNext;
      if (stb.commit && !stb.finish) begin
        acc[0]      <= satAdd(acc[0], selVal);
        acc[selIdx] <= decVal;
      end
      if (stb.finish) begin
        acc[0]   <= fire ? POT_W'(RESET_V) : decVal;
        spikeOut <= fire;
        if (fire)                refrCnt <= RW'(REFR_STEPS);
        else if (refrCnt != '0)  refrCnt <= refrCnt - 1'b1;
      end
    end
  end

  assign memOut = acc[0];
endmodule

// File: rtl/spikeNeuronPe.sv
module spikeNeuronPe
  import snpPkg::*;
#(
  parameter int NIN   = 12,
  parameter int NSYN  = 2,
  parameter int NTERM = 1,
  parameter logic [NIN*POT_W-1:0] WEIGHTS = {
    10'(-300), 10'(70), 10'(-40), 10'(30), 10'(50), 10'(-300),
    10'(511), 10'(200), 10'(60), 10'(100), 10'(-17), 10'(1)},
  parameter logic [NIN*4-1:0] TARGETS = {
    4'd0, 4'd0, 4'd1, 4'd2, 4'd1, 4'd0, 4'd0, 4'd0, 4'd2, 4'd1, 4'd0, 4'd0},
  parameter logic [(NSYN+1)*NTERM*4-1:0] SHIFTS = {4'd3, 4'd2, 4'd4},
  parameter int REFR_STEPS = 2,
  parameter int THRESH     = 255,
  parameter int RESET_V    = -255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NIN-1:0]   spikeIn,
  output logic             busy,
  output logic             done,
  output logic             spikeOut,
  output logic [POT_W-1:0] memOut
);
  localparam int STEP_TICKS = NIN + (NSYN + 1) * (NTERM + 1);

  strobe_t stb;
  pot_t    memVal;

  snpCtrl #(.NIN(NIN), .NSYN(NSYN), .NTERM(NTERM)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .busy(busy), .done(done), .stb(stb)
  );

  snpDatapath #(
    .NIN(NIN), .NSYN(NSYN), .NTERM(NTERM),
    .WEIGHTS(WEIGHTS), .TARGETS(TARGETS), .SHIFTS(SHIFTS),
    .REFR_STEPS(REFR_STEPS), .THRESH(THRESH), .RESET_V(RESET_V)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .spikeIn(spikeIn),
    .spikeOut(spikeOut), .memOut(memVal)
  );

  assign memOut = memVal;
endmodule

// File: rtl/spikeNeuronPeChk.sv
module spikeNeuronPeChk #(
  parameter int TICKS   = 18,
  parameter int POTW    = 10,
  parameter int THRESH  = 255,
  parameter int RESET_V = -255
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            spikeOut,
  input logic [POTW-1:0] memOut
);
  logic [15:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               busyCnt <= '0;
    else if (start && !busy) busyCnt <= '0;
    else if (busy)           busyCnt <= busyCnt + 1'b1;
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_step_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == 16'(TICKS)));

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(memOut));

  p_spike_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    spikeOut |-> done);

  p_fire_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    spikeOut |-> ($signed(memOut) == POTW'(RESET_V)));

  p_below_thresh_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !spikeOut) |-> (int'($signed(memOut)) < THRESH));
endmodule

bind spikeNeuronPe spikeNeuronPeChk #(
  .TICKS(STEP_TICKS), .POTW(snpPkg::POT_W), .THRESH(THRESH), .RESET_V(RESET_V)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .spikeOut(spikeOut), .memOut(memOut)
);

// File: tb/test_spikeNeuronPe.sv
module test_spikeNeuronPe;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] spikeIn = '0;
  logic        busy, done, spikeOut;
  logic [9:0]  memOut;

  always #2.5 clk = ~clk;

  spikeNeuronPe #(
    .NIN(12), .NSYN(2), .NTERM(1),
    .WEIGHTS({10'(-300), 10'(70), 10'(-40), 10'(30), 10'(50), 10'(-300),
              10'(511), 10'(200), 10'(60), 10'(100), 10'(-17), 10'(1)}),
    .TARGETS({4'd0, 4'd0, 4'd1, 4'd2, 4'd1, 4'd0, 4'd0, 4'd0, 4'd2, 4'd1, 4'd0, 4'd0}),
    .SHIFTS({4'd3, 4'd2, 4'd4}),
    .REFR_STEPS(2), .THRESH(255), .RESET_V(-255)
  ) i_spikeNeuronPe (
    .clk(clk), .rstN(rstN), .start(start), .spikeIn(spikeIn),
    .busy(busy), .done(done), .spikeOut(spikeOut), .memOut(memOut)
  );

  // bench configuration, from the requirements
  int wt[12]  = '{1, -17, 100, 60, 200, 511, -300, 50, 30, -40, 70, -300};
  int tgt[12] = '{0, 0, 1, 2, 0, 0, 0, 1, 2, 1, 0, 0};
  int sh[3]   = '{4, 2, 3};

  int nChk = 0, nFail = 0;
  int mAcc[3];
  int mRefr;
  bit mFire;
  int lastCyc;

  function automatic int sat(int v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  function automatic int decay(int y, int k);
    int s;
    bit c;
    s = y >>> k;
    c = (y > 0) && ((y & ((1 << k) - 1)) != 0);
    return y - s - (c ? 1 : 0);
  endfunction

  task automatic modelStep(input logic [11:0] pat);
    bit blocked;
    blocked = (mRefr != 0);
    for (int i = 0; i < 12; i++)
      if (pat[i] && !blocked) mAcc[tgt[i]] = sat(mAcc[tgt[i]] + wt[i]);
    for (int s = 1; s <= 2; s++) begin
      mAcc[0] = sat(mAcc[0] + mAcc[s]);
      mAcc[s] = decay(mAcc[s], sh[s]);
    end
    mAcc[0] = decay(mAcc[0], sh[0]);
    mFire = (mAcc[0] >= 255);
    if (mFire) mAcc[0] = -255;
    if (mFire) mRefr = 2;
    else if (mRefr > 0) mRefr--;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int memI();
    return int'($signed(memOut));
  endfunction

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0; start = 1'b0; spikeIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mAcc = '{0, 0, 0};
    mRefr = 0;
  endtask

  task automatic doStep(input logic [11:0] pat, input bit garble);
    @(negedge clk);
    spikeIn = pat; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (garble) spikeIn = '1;
    lastCyc = 0;
    while (!done && lastCyc < 100) begin
      @(negedge clk);
      lastCyc++;
    end
    modelStep(pat);
  endtask

  task automatic stepCheck(input logic [11:0] pat, input bit garble, input string req);
    doStep(pat, garble);
    check(memI() == mAcc[0], {req, " membrane"}, memI(), mAcc[0]);
    check(spikeOut == mFire, {req, " spike"}, int'(spikeOut), int'(mFire));
  endtask

  task automatic tReset();
    resetDut();
    check(memOut == '0, "R1 membrane", memI(), 0);
    check(!busy && !done && !spikeOut, "R1 flags",
          int'({busy, done, spikeOut}), 0);
  endtask

  task automatic tTiming();
    int dones;
    resetDut();
    doStep(12'h000, 1'b0);
    check(lastCyc == 18, "R2 step length", lastCyc, 18);
    @(negedge clk);
    check(!done, "R2 done width", int'(done), 0);
    // second start during busy must be ignored
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    for (int c = 0; c < 40; c++) begin
      if (c == 5) start = 1'b1;
      if (c == 6) start = 1'b0;
      @(negedge clk);
      if (done) dones++;
    end
    modelStep(12'h000);
    check(dones == 1, "R2 start while busy ignored", dones, 1);
  endtask

  task automatic tDecay();
    resetDut();
    stepCheck(12'h001, 1'b0, "R6");
    check(memI() == 0, "R6 positive 1 decays to 0", memI(), 0);
    resetDut();
    stepCheck(12'h002, 1'b0, "R5");
    check(memI() == -15, "R5 negative decay", memI(), -15);
    stepCheck(12'h000, 1'b0, "R5");
    check(memI() == -14, "R5 second decay", memI(), -14);
  endtask

  task automatic tFold();
    resetDut();
    stepCheck(12'h004, 1'b0, "R4");
    check(memI() == 93, "R4 fold then decay", memI(), 93);
    stepCheck(12'h000, 1'b0, "R4");
    check(memI() == 157, "R4 decayed synapse folds again", memI(), 157);
  endtask

  task automatic tTarget();
    resetDut();
    stepCheck(12'h008, 1'b1, "R3");
    check(memI() == 56, "R3 synapse 2 route, late spikes ignored", memI(), 56);
    stepCheck(12'h000, 1'b0, "R3");
  endtask

  task automatic tFireRefr();
    resetDut();
    stepCheck(12'h020, 1'b0, "R7");
    check(spikeOut && memI() == -255, "R7 fire and reset", memI(), -255);
    stepCheck(12'h020, 1'b0, "R8");
    check(memI() == -239, "R8 input blocked step 1", memI(), -239);
    stepCheck(12'h020, 1'b0, "R8");
    check(memI() == -224, "R8 input blocked step 2", memI(), -224);
    stepCheck(12'h020, 1'b0, "R8");
    check(spikeOut == 1'b1, "R8 inputs accepted again", int'(spikeOut), 1);
  endtask

  task automatic tSaturate();
    resetDut();
    stepCheck(12'h840, 1'b0, "R9");
    check(memI() == -480, "R9 negative clamp", memI(), -480);
    resetDut();
    stepCheck(12'h030, 1'b0, "R9");
    check(spikeOut == 1'b1, "R9 positive clamp fires", int'(spikeOut), 1);
  endtask

  task automatic tRandom();
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    resetDut();
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stepCheck(lfsr[11:0] & {lfsr[3:0], lfsr[15:8]}, n[0], "R3 random");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    tReset();
    tTiming();
    tDecay();
    tFold();
    tTarget();
    tFireRefr();
    tSaturate();
    tRandom();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule